// File: doc/BRIEF.md
# Interrupt enable and halt controller

This block sits beside the fetch and decode logic of a small 8-bit processor and owns two pieces of control state. The first is the master interrupt enable. The second is the low-power halted state. Decode reports each completed instruction with a boundary strobe. Three qualifiers come with that strobe: one for the enable instruction, one for the disable instruction and one for the halt instruction.

The block combines a 5-bit source-enable mask with a 5-bit request vector. From these it decides, at each boundary or while halted, one of four things: start an interrupt service, put the core to sleep, wake it up, or tell fetch to skip one program-counter increment.

A service is reported one cycle after the decision as a single-cycle pulse. The pulse comes with a one-hot acknowledge of the chosen source and that source's vector. Clearing the acknowledged request bit is left to the surrounding logic.

Top module: `irq_halt_ctrl`

## Requirements
- R1: While reset is held low, and in the first cycle after it, `ime_o`, `halted_o`, `svc_req_o` and `skip_inc_o` are 0, and `svc_ack_o` and `svc_vec_o` are all zeros.
- R2: A boundary carrying the enable qualifier leaves `ime_o` unchanged. `ime_o` becomes 1 at the next boundary that does not carry the disable qualifier, and a service may be started at that same boundary. `ime_o` never rises except at a boundary that is accepted while not halted.
- R3: A boundary carrying the disable qualifier makes `ime_o` 0 in the following cycle. It also cancels an enable whose one-instruction delay is still running, so `ime_o` stays 0 after later plain boundaries. The disable qualifier wins when both are given together.
- R4: An interrupt is pending when `ien_i & ireq_i` is non-zero. A service is started at an accepted boundary when the master enable is on after that boundary's own effect and something is pending. One cycle later, `svc_req_o` is 1 for exactly one cycle and `ime_o` reads 0.
- R5: The serviced source is the pending one with the lowest bit number. `svc_ack_o` has only that bit set, and `svc_vec_o` equals 8 times its index (0x00, 0x08, 0x10, 0x18, 0x20). Both outputs are zero when `svc_req_o` is 0.
- R6: The halt qualifier with the master enable on and nothing pending sets `halted_o`. It stays set until something becomes pending. In the cycle after that, `halted_o` is 0 and a service is reported.
- R7: The halt qualifier with the master enable off and nothing pending sets `halted_o`. When something becomes pending, `halted_o` clears one cycle later with no service, and `ime_o` stays 0.
- R8: The halt qualifier with the master enable off and something already pending does not halt. Instead `skip_inc_o` is 1 for the one cycle after that boundary, the next fetch, and 0 again afterwards unless another such boundary occurs.
- R9: The halt qualifier with the master enable on and something pending starts a service at once and does not set `halted_o`.
- R10: While `halted_o` is 1, boundary strobes and their qualifiers are ignored. In particular a disable given while halted leaves `ime_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bnd_i | input | 1 | An instruction completes this cycle |
| ei_i | input | 1 | Completing instruction is the enable instruction |
| di_i | input | 1 | Completing instruction is the disable instruction |
| halt_i | input | 1 | Completing instruction is the halt instruction |
| ien_i | input | 5 | Per-source interrupt enable mask |
| ireq_i | input | 5 | Per-source interrupt request flags |
| ime_o | output | 1 | Master interrupt enable |
| halted_o | output | 1 | Core is in the halted low-power state |
| svc_req_o | output | 1 | One-cycle service request pulse |
| svc_vec_o | output | 8 | Service vector of the chosen source |
| svc_ack_o | output | 5 | One-hot acknowledge of the chosen source |
| skip_inc_o | output | 1 | Suppress the program-counter increment of the next fetch |

## Verification
Directed sequences cover each halt outcome: enable on or off, each combined with nothing pending or with a request already waiting. The halted-wakeup path and the skip path can only be told apart by the order in which the enable, halt and request events arrive.

Other directed cases separate an enable delay that runs out from one that a disable cancels. They also include a disable sent while halted, which must be ignored, and requests hidden by the enable mask, which must not wake the core.

Random streams mix boundaries, qualifiers, masks and sparse multi-bit requests, so that priority between sources and back-to-back events are exercised beyond the directed cases.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Outcome of an accepted boundary or a halted cycle
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_SLEEP = 2'd1,
        ACT_SKIP  = 2'd2,
        ACT_SERVE = 2'd3
    } irq_act_e;

    function automatic irq_act_e pick_act(
        input logic bnd_ok,
        input logic halt,
        input logic sleeping,
        input logic ime_eff,
        input logic pend
    );
        irq_act_e a;
        a = ACT_NONE;
        if (sleeping) begin
            if (pend && ime_eff) a = ACT_SERVE;
        end else if (bnd_ok) begin
            if (pend && ime_eff)      a = ACT_SERVE;
            else if (halt && !pend)   a = ACT_SLEEP;
            else if (halt && pend)    a = ACT_SKIP;
        end
        return a;
    endfunction

endpackage

// File: rtl/irq_pend_sel.sv
module irq_pend_sel #(
    parameter int N_SRC = 5,
    parameter int IDX_W = 3
) (
    input  logic [N_SRC-1:0] en_i,
    input  logic [N_SRC-1:0] req_i,
    output logic             any_o,
    output logic [N_SRC-1:0] ack_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [N_SRC-1:0] hit;
    assign hit   = en_i & req_i;
    assign any_o = |hit;

    // one-hot of the lowest set bit
    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_win
            if (g == 0) begin : g_first
                assign ack_o[g] = hit[g];
            end else begin : g_rest
                assign ack_o[g] = hit[g] & ~(|hit[g-1:0]);
            end
        end
    endgenerate

    always_comb begin
        idx_o = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (hit[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_ime_ctl.sv
module irq_ime_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic bnd_ok_i,
    input  logic ei_i,
    input  logic di_i,
    input  logic serve_i,
    output logic ime_q_o,
    output logic ime_eff_o
);
    typedef struct packed {
        logic ime;
        logic armed;
    } ime_st_t;

    ime_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        ime_eff_o = st_q.ime;
        if (bnd_ok_i) begin
            if (di_i) begin
                ime_eff_o = 1'b0;
                st_d.armed = 1'b0;
            end else begin
                ime_eff_o = st_q.ime | st_q.armed;
                st_d.armed = ei_i;
            end
            st_d.ime = ime_eff_o;
        end
        if (serve_i) begin
            st_d.ime   = 1'b0;
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ime_q_o = st_q.ime;
endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl #(
    parameter int N_SRC      = 5,
    parameter int VEC_W      = 8,
    parameter int VEC_STRIDE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bnd_i,
    input  logic             ei_i,
    input  logic             di_i,
    input  logic             halt_i,
    input  logic [N_SRC-1:0] ien_i,
    input  logic [N_SRC-1:0] ireq_i,
    output logic             ime_o,
    output logic             halted_o,
    output logic             svc_req_o,
    output logic [VEC_W-1:0] svc_vec_o,
    output logic [N_SRC-1:0] svc_ack_o,
    output logic             skip_inc_o
);
    import irq_pkg::*;

    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    typedef struct packed {
        logic             halted;
        logic             svc;
        logic [VEC_W-1:0] vec;
        logic [N_SRC-1:0] ack;
        logic             skip;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic             pend;
    logic [N_SRC-1:0] win_ack;
    logic [IDX_W-1:0] win_idx;
    logic             bnd_ok, ime_q, ime_eff, serve;
    irq_act_e         act;

    irq_pend_sel #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_sel (
        .en_i  (ien_i),
        .req_i (ireq_i),
        .any_o (pend),
        .ack_o (win_ack),
        .idx_o (win_idx)
    );

    assign bnd_ok = bnd_i & ~st_q.halted;

    irq_ime_ctl u_ime (
        .clk       (clk),
        .rst_n     (rst_n),
        .bnd_ok_i  (bnd_ok),
        .ei_i      (ei_i),
        .di_i      (di_i),
        .serve_i   (serve),
        .ime_q_o   (ime_q),
        .ime_eff_o (ime_eff)
    );

    assign act   = pick_act(bnd_ok, halt_i, st_q.halted, ime_eff, pend);
    assign serve = (act == ACT_SERVE);

    always_comb begin
        st_d      = '0;
        st_d.svc  = serve;
        st_d.skip = (act == ACT_SKIP);
        if (serve) begin
            st_d.ack = win_ack;
            st_d.vec = VEC_W'(int'(win_idx) * VEC_STRIDE);
        end
        if (st_q.halted) st_d.halted = ~pend;
        else             st_d.halted = (act == ACT_SLEEP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ime_o      = ime_q;
    assign halted_o   = st_q.halted;
    assign svc_req_o  = st_q.svc;
    assign svc_vec_o  = st_q.vec;
    assign svc_ack_o  = st_q.ack;
    assign skip_inc_o = st_q.skip;
endmodule

// File: rtl/irq_halt_chk.sv
module irq_halt_chk #(
    parameter int N_SRC = 5,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bnd_i,
    input logic             di_i,
    input logic             halt_i,
    input logic [N_SRC-1:0] ien_i,
    input logic [N_SRC-1:0] ireq_i,
    input logic             ime_o,
    input logic             halted_o,
    input logic             svc_req_o,
    input logic [VEC_W-1:0] svc_vec_o,
    input logic [N_SRC-1:0] svc_ack_o,
    input logic             skip_inc_o
);
    AST_IME_RISE_AT_BND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ime_o) |-> $past(bnd_i && !halted_o && !di_i)); // R2

    AST_DI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bnd_i && di_i && !halted_o) |-> !ime_o); // R3

    AST_SVC_DROPS_IME: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req_o |-> !ime_o); // R4

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req_o |-> $onehot(svc_ack_o)); // R5

    AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !svc_req_o |-> (svc_ack_o == '0 && svc_vec_o == '0)); // R5

    AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req_o |-> (svc_vec_o[2:0] == 3'b000)); // R5

    AST_STAY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && $past(halted_o)) |-> ($past(ien_i & ireq_i) == '0)); // R6

    AST_SKIP_NOT_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        skip_inc_o |-> (!halted_o && $past(bnd_i && halt_i))); // R8
endmodule

bind irq_halt_ctrl irq_halt_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bnd_i      (bnd_i),
    .di_i       (di_i),
    .halt_i     (halt_i),
    .ien_i      (ien_i),
    .ireq_i     (ireq_i),
    .ime_o      (ime_o),
    .halted_o   (halted_o),
    .svc_req_o  (svc_req_o),
    .svc_vec_o  (svc_vec_o),
    .svc_ack_o  (svc_ack_o),
    .skip_inc_o (skip_inc_o)
);

// File: tb/irq_halt_ctrl_test.sv
module irq_halt_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bnd_i = 1'b0, ei_i = 1'b0, di_i = 1'b0, halt_i = 1'b0;
    logic [4:0] ien_i = '0, ireq_i = '0;
    logic       ime_o, halted_o, svc_req_o, skip_inc_o;
    logic [7:0] svc_vec_o;
    logic [4:0] svc_ack_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference state
    logic m_ime = 0, m_arm = 0, m_halt = 0, m_svc = 0, m_skip = 0;
    logic [7:0] m_vec = '0;
    logic [4:0] m_ack = '0;

    irq_halt_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bnd_i(bnd_i), .ei_i(ei_i), .di_i(di_i),
        .halt_i(halt_i), .ien_i(ien_i), .ireq_i(ireq_i), .ime_o(ime_o),
        .halted_o(halted_o), .svc_req_o(svc_req_o), .svc_vec_o(svc_vec_o),
        .svc_ack_o(svc_ack_o), .skip_inc_o(skip_inc_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] low_idx(input logic [4:0] v);
        for (int i = 4; i >= 0; i--) if (v[i]) low_idx = 3'(i);
        if (v == 0) low_idx = 0;
    endfunction

    // advance the reference by one clock from the current inputs
    task automatic model_step();
        logic pend, bok, eff, go;
        logic [4:0] p;
        p    = ien_i & ireq_i;
        pend = |p;
        bok  = bnd_i && !m_halt;
        eff  = bok ? (di_i ? 1'b0 : (m_ime | m_arm)) : m_ime;
        go   = pend && ((bok && eff) || (m_halt && m_ime));
        m_skip = bok && halt_i && !eff && pend;
        m_svc  = go;
        m_vec  = go ? {2'b00, low_idx(p), 3'b000} : 8'h00;
        m_ack  = go ? (5'b1 << low_idx(p)) : 5'b0;
        if (go) begin
            m_ime = 0; m_arm = 0;
        end else if (bok) begin
            m_ime = eff; m_arm = ei_i && !di_i;
        end
        m_halt = m_halt ? !pend : (bok && halt_i && !go && !pend);
    endtask

    task automatic compare();
        chk("R3 ime", ime_o, m_ime);
        chk("R6 halted", halted_o, m_halt);
        chk("R4 svc_req", svc_req_o, m_svc);
        chk("R5 vec", svc_vec_o, m_vec);
        chk("R5 ack", svc_ack_o, m_ack);
        chk("R8 skip", skip_inc_o, m_skip);
    endtask

    // inputs are set after a falling edge; outputs read at the next falling edge
    task automatic step(input logic b, input logic e, input logic d, input logic h);
        bnd_i = b; ei_i = e; di_i = d; halt_i = h;
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        bnd_i = 0; ei_i = 0; di_i = 0; halt_i = 0;
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        chk("R1 ime", ime_o, 0);
        chk("R1 halted", halted_o, 0);
        chk("R1 svc", svc_req_o, 0);
        chk("R1 skip", skip_inc_o, 0);
        @(negedge clk); rst_n = 1;
        step(0, 0, 0, 0);
        chk("R1 ack after reset", svc_ack_o, 0);

        // R2: one-instruction delay
        ien_i = 5'h1F; ireq_i = 0;
        step(1, 1, 0, 0);
        chk("R2 ime held after EI", ime_o, 0);
        step(1, 0, 0, 0);
        chk("R2 ime set next boundary", ime_o, 1);

        // R3: disable and cancel
        step(1, 0, 1, 0);
        chk("R3 di clears", ime_o, 0);
        step(1, 1, 0, 0);
        step(1, 0, 1, 0);
        step(1, 0, 0, 0);
        chk("R3 cancelled enable", ime_o, 0);
        step(1, 1, 1, 0);
        step(1, 0, 0, 0);
        chk("R3 di wins over ei", ime_o, 0);

        // R4/R5: service with priority
        step(1, 1, 0, 0);
        step(1, 0, 0, 0);
        ireq_i = 5'b10100;
        step(1, 0, 0, 0);
        chk("R4 svc pulse", svc_req_o, 1);
        chk("R4 ime dropped", ime_o, 0);
        chk("R5 vec", svc_vec_o, 8'h10);
        chk("R5 ack", svc_ack_o, 5'b00100);
        ireq_i = 0;
        step(0, 0, 0, 0);
        chk("R4 single pulse", svc_req_o, 0);

        // R2: service taken at the boundary where the delay expires
        step(1, 1, 0, 0);
        ireq_i = 5'b01000;
        step(1, 0, 0, 0);
        chk("R2 service at expiry", svc_req_o, 1);
        chk("R5 vec src3", svc_vec_o, 8'h18);
        ireq_i = 0;

        // R6 and R10: halt with enable on, disable ignored while halted
        step(1, 1, 0, 0);
        step(1, 0, 0, 0);
        step(1, 0, 0, 1);
        chk("R6 halted", halted_o, 1);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        chk("R6 still halted", halted_o, 1);
        step(1, 0, 1, 0);
        chk("R10 ime kept", ime_o, 1);
        chk("R10 still halted", halted_o, 1);
        ireq_i = 5'b10000;
        step(0, 0, 0, 0);
        chk("R6 woke", halted_o, 0);
        chk("R6 serviced", svc_req_o, 1);
        chk("R5 vec src4", svc_vec_o, 8'h20);
        ireq_i = 0;

        // R7: halt with enable off
        step(1, 0, 0, 1);
        chk("R7 halted", halted_o, 1);
        ireq_i = 5'b00010;
        step(0, 0, 0, 0);
        chk("R7 woke", halted_o, 0);
        chk("R7 no service", svc_req_o, 0);
        chk("R7 ime off", ime_o, 0);

        // R8: halt with enable off and pending
        ireq_i = 5'b00001;
        step(1, 0, 0, 1);
        chk("R8 not halted", halted_o, 0);
        chk("R8 skip", skip_inc_o, 1);
        step(1, 0, 0, 0);
        chk("R8 skip one fetch", skip_inc_o, 0);

        // R4: masked requests are not pending
        ien_i = 0; ireq_i = 5'h1F;
        step(1, 0, 0, 1);
        chk("R4 masked halts", halted_o, 1);
        ien_i = 5'b00100;
        step(0, 0, 0, 0);
        chk("R4 unmasked wakes", halted_o, 0);

        // R9: halt with enable on and pending
        ien_i = 5'h1F; ireq_i = 0;
        step(1, 1, 0, 0);
        step(1, 0, 0, 0);
        ireq_i = 5'b00110;
        step(1, 0, 0, 1);
        chk("R9 serviced", svc_req_o, 1);
        chk("R9 not halted", halted_o, 0);
        chk("R9 vec src1", svc_vec_o, 8'h08);
        ireq_i = 0;

        // random mix
        for (int k = 0; k < 4000; k++) begin
            int unsigned r, q;
            r = $urandom % 8;
            q = $urandom % 5;
            ien_i  = 5'($urandom);
            ireq_i = (q == 0) ? 5'($urandom) : 5'b0;
            step(r[0], r[2:1] == 2'd1, r[2:1] == 2'd2, r[2:1] == 2'd3);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule